// File: doc/BRIEF.md
# Atomic Split Result Register

This block holds the latest 10-bit conversion result and presents it to an 8-bit bus as a high byte and a low byte. A conversion engine delivers each result with a one-cycle write strobe. The bus side issues one-cycle read strobes for the low and high halves. An adjust-select input chooses how the stored value is laid out across the two bytes. Every completion strobe is forwarded as a one-cycle interrupt pulse, whether or not its result was kept.

To keep a low-then-high read pair coherent, a small state machine with the states `ST_OPEN` and `ST_LOCKED` guards the stored value. The LOCK transition (`ST_OPEN` to `ST_LOCKED`) is taken on a low-byte read. The RELEASE transition (`ST_LOCKED` to `ST_OPEN`) is taken on a high-byte read. In every other cycle the state holds.

Results that arrive while the register is locked are thrown away. A result that arrives in the same cycle as either read strobe is also thrown away. Software that only needs the top eight bits can use the left-adjusted layout and read the high byte alone, which never locks the register.

Top module: `split_result_reg`

## Requirements
- R1: After reset both bytes read 0x00, the register is unlocked and `irq` is low.
- R2: With `left_adj` low, `hi_byte` is {6'b0, value[9:8]} and `lo_byte` is value[7:0].
- R3: With `left_adj` high, `hi_byte` is value[9:2] and `lo_byte` is {value[1:0], 6'b0}.
- R4: `left_adj` only changes how the stored value is presented. Toggling it re-maps the outputs in the same cycle, and no new result is needed.
- R5: A write strobe is accepted when the register is unlocked and neither read strobe is high in that cycle. The new value appears on the byte outputs in the cycle after the strobe.
- R6: A low-byte read locks the register. While it is locked, write strobes leave both bytes unchanged.
- R7: A high-byte read unlocks the register, so the next qualifying write strobe is accepted.
- R8: `irq` is high for exactly the cycle after each write strobe, including strobes whose result was discarded.
- R9: A high-byte read on its own never locks the register.
- R10: A write strobe in the same cycle as a high-byte or low-byte read is discarded. The read returns the old data, and a high-byte read still unlocks the register.
- R11: A low-byte read and a high-byte read in the same cycle leave the register unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_data | input | 10 | Result from the conversion engine |
| res_wr | input | 1 | One-cycle completion strobe for `res_data` |
| rd_lo | input | 1 | Low-byte read strobe |
| rd_hi | input | 1 | High-byte read strobe |
| left_adj | input | 1 | 1 = left-adjusted layout, 0 = right-adjusted layout |
| lo_byte | output | 8 | Low byte of the presented result |
| hi_byte | output | 8 | High byte of the presented result |
| irq | output | 1 | Completion interrupt pulse |

## Verification
A lock state that sticks in `ST_LOCKED` shows up at the ports on the next completion. The bytes keep their old value even though `irq` pulses. A state that never locks shows up as soon as a completion lands between a low read and a high read, because the high byte then changes in the cycle after that strobe. A store-enable that ignores the read strobes is caught by the coincident-strobe scenarios, where the bytes must stay at their old values. Layout mistakes appear combinationally, in the same cycle that `left_adj` changes.

// File: rtl/srr_pkg.sv
package srr_pkg;
    typedef enum logic {
        ST_OPEN   = 1'b0,
        ST_LOCKED = 1'b1
    } lock_state_e;
endpackage

// File: rtl/srr_lock_fsm.sv
module srr_lock_fsm
    import srr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic res_wr,
    input  logic rd_lo,
    input  logic rd_hi,
    output logic locked,
    output logic accept
);
    lock_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPEN:   if (rd_lo && !rd_hi) state_d = ST_LOCKED; // LOCK
            ST_LOCKED: if (rd_hi)           state_d = ST_OPEN;   // RELEASE
            default:                        state_d = ST_OPEN;
        endcase
    end

    always_comb begin
        locked = 1'b0;
        accept = 1'b0;
        unique case (state_q)
            ST_OPEN:   accept = res_wr && !rd_lo && !rd_hi;
            ST_LOCKED: locked = 1'b1;
            default:   ;
        endcase
    end
endmodule

// File: rtl/srr_store.sv
module srr_store #(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             res_wr,
    input  logic [RES_W-1:0] res_data,
    output logic [RES_W-1:0] stored_q,
    output logic             irq_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stored_q <= '0;
            irq_q    <= 1'b0;
        end else begin
            if (accept) stored_q <= res_data;
            irq_q <= res_wr;
        end
    end
endmodule

// File: rtl/srr_format.sv
module srr_format #(
    parameter int RES_W = 10,
    parameter int BUS_W = 8
) (
    input  logic [RES_W-1:0] value,
    input  logic             left_adj,
    output logic [BUS_W-1:0] lo_byte,
    output logic [BUS_W-1:0] hi_byte
);
    localparam int W2  = 2 * BUS_W;
    localparam int PAD = W2 - RES_W;

    logic [W2-1:0] right_w, left_w, sel_w;

    always_comb begin
        right_w = W2'(value);
        left_w  = right_w << PAD;
        sel_w   = left_adj ? left_w : right_w;
        hi_byte = sel_w[W2-1:BUS_W];
        lo_byte = sel_w[BUS_W-1:0];
    end
endmodule

// File: rtl/split_result_reg.sv
module split_result_reg #(
    parameter int RES_W = 10,
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [RES_W-1:0] res_data,
    input  logic             res_wr,
    input  logic             rd_lo,
    input  logic             rd_hi,
    input  logic             left_adj,
    output logic [BUS_W-1:0] lo_byte,
    output logic [BUS_W-1:0] hi_byte,
    output logic             irq
);
    logic             locked;
    logic             accept;
    logic [RES_W-1:0] stored_q;

    srr_lock_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .res_wr (res_wr),
        .rd_lo  (rd_lo),
        .rd_hi  (rd_hi),
        .locked (locked),
        .accept (accept)
    );

    srr_store #(.RES_W(RES_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .res_wr   (res_wr),
        .res_data (res_data),
        .stored_q (stored_q),
        .irq_q    (irq)
    );

    srr_format #(.RES_W(RES_W), .BUS_W(BUS_W)) u_fmt (
        .value    (stored_q),
        .left_adj (left_adj),
        .lo_byte  (lo_byte),
        .hi_byte  (hi_byte)
    );
endmodule

// File: rtl/srr_checker.sv
module srr_checker #(
    parameter int RES_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             res_wr,
    input logic [RES_W-1:0] res_data,
    input logic             rd_lo,
    input logic             rd_hi,
    input logic             irq,
    input logic             locked,
    input logic [RES_W-1:0] stored
);
    a_r8_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
        res_wr |=> irq);
    a_r8_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !res_wr |=> !irq);
    a_r5_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (res_wr && !locked && !rd_lo && !rd_hi) |=> stored == $past(res_data));
    a_r6_hold_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !rd_hi) |=> ($stable(stored) && locked));
    a_r10_coincident: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lo || rd_hi) |=> $stable(stored));
    a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hi |=> !locked);
    a_r6_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lo && !rd_hi) |=> locked);
endmodule

bind split_result_reg srr_checker #(.RES_W(RES_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .res_wr   (res_wr),
    .res_data (res_data),
    .rd_lo    (rd_lo),
    .rd_hi    (rd_hi),
    .irq      (irq),
    .locked   (locked),
    .stored   (stored_q)
);

// File: tb/split_result_reg_bench.sv
module split_result_reg_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] res_data = '0;
    logic       res_wr = 1'b0;
    logic       rd_lo = 1'b0;
    logic       rd_hi = 1'b0;
    logic       left_adj = 1'b0;
    logic [7:0] lo_byte, hi_byte;
    logic       irq;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    split_result_reg u_split_result_reg (
        .clk(clk), .rst_n(rst_n), .res_data(res_data), .res_wr(res_wr),
        .rd_lo(rd_lo), .rd_hi(rd_hi), .left_adj(left_adj),
        .lo_byte(lo_byte), .hi_byte(hi_byte), .irq(irq)
    );

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic bytes_are(string req, logic [7:0] h, logic [7:0] l);
        check(req, {hi_byte, lo_byte}, {h, l});
    endtask

    // write strobe for one cycle; irq checked in the following cycle (R8)
    task automatic push(logic [9:0] v);
        res_data = v;
        res_wr = 1'b1;
        cyc();
        res_wr = 1'b0;
        check("R8 irq after strobe", 16'(irq), 16'd1);
        cyc();
        check("R8 irq single cycle", 16'(irq), 16'd0);
    endtask

    task automatic t_reset();
        bytes_are("R1 reset bytes", 8'h00, 8'h00);
        check("R1 reset irq", 16'(irq), 16'd0);
    endtask

    task automatic t_right();
        left_adj = 1'b0;
        push(10'h2B5);
        bytes_are("R2 R5 right layout", 8'h02, 8'hB5);
    endtask

    task automatic t_left();
        left_adj = 1'b1;
        #1;
        bytes_are("R3 R4 left layout remap", 8'hAD, 8'h40);
        left_adj = 1'b0;
        #1;
        bytes_are("R4 back to right", 8'h02, 8'hB5);
    endtask

    task automatic t_lock();
        rd_lo = 1'b1;
        #1;
        check("R6 low read value", 16'(lo_byte), 16'h00B5);
        cyc();
        rd_lo = 1'b0;
        push(10'h123);
        bytes_are("R6 locked write dropped", 8'h02, 8'hB5);
        rd_hi = 1'b1;
        #1;
        check("R7 high read pairs", 16'(hi_byte), 16'h0002);
        cyc();
        rd_hi = 1'b0;
        push(10'h123);
        bytes_are("R7 released write taken", 8'h01, 8'h23);
    endtask

    task automatic t_hionly();
        left_adj = 1'b1;
        rd_hi = 1'b1;
        cyc();
        rd_hi = 1'b0;
        push(10'h3FF);
        bytes_are("R9 high-only read no lock", 8'hFF, 8'hC0);
    endtask

    task automatic t_coinc();
        rd_lo = 1'b1;
        cyc();
        rd_lo = 1'b0;
        res_data = 10'h0AA;
        res_wr = 1'b1;
        rd_hi = 1'b1;
        #1;
        check("R10 coincident read old", 16'(hi_byte), 16'h00FF);
        cyc();
        res_wr = 1'b0;
        rd_hi = 1'b0;
        check("R10 coincident irq", 16'(irq), 16'd1);
        bytes_are("R10 coincident write dropped", 8'hFF, 8'hC0);
        push(10'h0AA);
        bytes_are("R10 R7 unlocked after", 8'h2A, 8'h80);
        res_data = 10'h155;
        res_wr = 1'b1;
        rd_lo = 1'b1;
        cyc();
        res_wr = 1'b0;
        rd_lo = 1'b0;
        bytes_are("R10 write with low read dropped", 8'h2A, 8'h80);
        rd_hi = 1'b1;
        cyc();
        rd_hi = 1'b0;
    endtask

    task automatic t_both();
        rd_lo = 1'b1;
        rd_hi = 1'b1;
        cyc();
        rd_lo = 1'b0;
        rd_hi = 1'b0;
        push(10'h001);
        bytes_are("R11 both reads stay unlocked", 8'h00, 8'h40);
        left_adj = 1'b0;
        #1;
        bytes_are("R11 R2 right view", 8'h00, 8'h01);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 2 + 3);
        t_reset();
        rst_n = 1'b1;
        cyc();
        t_reset();
        t_right();
        t_left();
        t_lock();
        t_hionly();
        t_coinc();
        t_both();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule